// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block stores the floating-point registers of a processor core in a single array of 32-bit words. The same bits can be read and written at three widths: single (32 bits), double (64 bits) and quad (128 bits). Each port has a precision code that sets two things. It sets how the register number is read, and it sets how many words move across the 128-bit data bus. An optional extended bank adds more doubles. These doubles can be reached as double or quad registers only, and have no single view.

There is one write port and one read port. A write takes effect at the clock edge. A read is registered, so its result appears one cycle after the request. If a write in the same cycle touches the words being read, the read returns the new data, whatever precision each port uses. An access that names a register the selected precision cannot reach raises a one-cycle flag on its port. Such a write leaves all registers unchanged, and such a read returns zero.

The design has no state machine of its own. It is built from a register-number decoder, used once per port, a word bank, and a merge stage in the top module. That stage forwards writes to the read port and packs the read words onto the bus.

Top module: `fp_alias_regfile`

## Requirements
- R1: After reset every storage word reads as zero, and `rd_data`, `rd_illegal` and `wr_illegal` are zero.
- R2: Precision code 2'b00 is single. Single register s (s < 32) moves on data bits [31:0], and a read returns zero in bits [127:32]. Single 2k is the upper half (bits [63:32]) of double k, and single 2k+1 is the lower half.
- R3: A single write changes only its own 32 bits. The other half of the same double keeps its value.
- R4: Precision code 2'b01 is double. Double k moves on bits [63:0] and reads as {single 2k, single 2k+1}, with bits [127:64] read as zero.
- R5: Precision code 2'b10 is quad, named by an even double index q. Bits [127:64] hold double q and bits [63:0] hold double q+1.
- R6: A quad access with an odd index is illegal. As a write it pulses `wr_illegal` one cycle later and changes no storage. As a read it pulses `rd_illegal` one cycle later with `rd_data` zero.
- R7: With the extended bank present, doubles 16 to 31 are reachable as double and quad registers. A single index of 32 or above is illegal, and follows the same flag and no-change rules as R6.
- R8: Precision code 2'b11, or a double or quad index of 32 or above, is illegal on either port and follows the rules of R6.
- R9: A read issued while `rd_en` is high gives its result on `rd_data` and `rd_illegal` after the next clock edge. While `rd_en` is low, `rd_data` holds its value.
- R10: A read in the same cycle as a legal write returns the data after that write, including when the two ports use different precisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| rd_en | input | 1 | Read request |
| rd_prec | input | 2 | Read precision code |
| rd_idx | input | 6 | Read register number |
| rd_data | output | 128 | Registered read data |
| rd_illegal | output | 1 | Previous read was illegal |
| wr_en | input | 1 | Write request |
| wr_prec | input | 2 | Write precision code |
| wr_idx | input | 6 | Write register number |
| wr_data | input | 128 | Write data, right aligned |
| wr_illegal | output | 1 | Previous write was illegal |

## Verification
Every result is due exactly one clock edge after the stimulus: read data, both illegal flags, and the effect of a write as seen by a later read. The driver applies one operation at each falling edge. At the same moment it pushes the expected result, computed from a word-level model that has already applied that cycle's write, so forwarded reads are checked as well. The monitor takes the item off the queue 2 ns after the next rising edge and compares it against the ports. Idle cycles push an item that expects `rd_data` to be unchanged.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
    typedef enum logic [1:0] {
        PREC_SGL  = 2'b00,
        PREC_DBL  = 2'b01,
        PREC_QUAD = 2'b10,
        PREC_RSV  = 2'b11
    } prec_e;

    localparam int WORD_W = 32;
    localparam int BUS_W  = 128;
    localparam int LANES  = BUS_W / WORD_W;
endpackage

// File: rtl/fpr_decode.sv
module fpr_decode
    import fpr_pkg::*;
#(
    parameter int BASE_DBL = 16,
    parameter int NUM_DBL  = 32,
    parameter int IDX_W    = 6,
    localparam int BASE_W  = IDX_W + 1
) (
    input  logic [1:0]        prec,
    input  logic [IDX_W-1:0]  idx,
    output logic              legal,
    output logic [BASE_W-1:0] base,
    output logic [2:0]        nwords
);
    localparam int SGL_LIM = 2 * BASE_DBL;

    always_comb begin
        legal  = 1'b0;
        base   = '0;
        nwords = 3'd0;
        unique case (prec_e'(prec))
            PREC_SGL: begin
                legal  = int'(idx) < SGL_LIM;
                base   = {1'b0, idx};
                nwords = 3'd1;
            end
            PREC_DBL: begin
                legal  = int'(idx) < NUM_DBL;
                base   = {idx, 1'b0};
                nwords = 3'd2;
            end
            PREC_QUAD: begin
                legal  = (int'(idx) < NUM_DBL) && !idx[0];
                base   = {idx, 1'b0};
                nwords = 3'd4;
            end
            PREC_RSV: begin
                legal  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
    import fpr_pkg::*;
#(
    parameter int NW = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NW-1:0]                we,
    input  logic [NW-1:0][WORD_W-1:0]    wdata,
    output logic [NW-1:0][WORD_W-1:0]    words
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[w] <= '0;
            else if (we[w])
                words[w] <= wdata[w];
        end
    end

    // R2/R4/R5: one write touches exactly 0, 1, 2 or 4 words
    a_r5_write_span: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(we) == 0) || ($countones(we) == 1) ||
        ($countones(we) == 2) || ($countones(we) == 4));
endmodule

// File: rtl/fp_alias_regfile.sv
module fp_alias_regfile
    import fpr_pkg::*;
#(
    parameter int BASE_DBL = 16,
    parameter int EXT_DBL  = 16,
    parameter bit HAS_EXT  = 1'b1,
    parameter int IDX_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [1:0]         rd_prec,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [127:0]       rd_data,
    output logic               rd_illegal,
    input  logic               wr_en,
    input  logic [1:0]         wr_prec,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [127:0]       wr_data,
    output logic               wr_illegal
);
    localparam int NUM_DBL = BASE_DBL + (HAS_EXT ? EXT_DBL : 0);
    localparam int NW      = 2 * NUM_DBL;
    localparam int BASE_W  = IDX_W + 1;

    logic              w_legal, r_legal;
    logic [BASE_W-1:0] w_base, r_base;
    logic [2:0]        w_n, r_n;

    fpr_decode #(.BASE_DBL(BASE_DBL), .NUM_DBL(NUM_DBL), .IDX_W(IDX_W)) u_wdec (
        .prec(wr_prec), .idx(wr_idx), .legal(w_legal), .base(w_base), .nwords(w_n)
    );
    fpr_decode #(.BASE_DBL(BASE_DBL), .NUM_DBL(NUM_DBL), .IDX_W(IDX_W)) u_rdec (
        .prec(rd_prec), .idx(rd_idx), .legal(r_legal), .base(r_base), .nwords(r_n)
    );

    logic [NW-1:0]             we;
    logic [NW-1:0][WORD_W-1:0] wdat;
    logic [NW-1:0][WORD_W-1:0] words;
    logic [NW-1:0][WORD_W-1:0] post;

    // Write lane steering: word base+i takes bus lane n-1-i (big-endian)
    for (genvar w = 0; w < NW; w++) begin : g_lane
        int  off;
        logic [1:0] lane;
        always_comb begin
            off     = w - int'(w_base);
            lane    = 2'(int'(w_n) - 1 - off);
            we[w]   = wr_en && w_legal && (off >= 0) && (off < int'(w_n));
            wdat[w] = wr_data[lane*WORD_W +: WORD_W];
            post[w] = we[w] ? wdat[w] : words[w];
        end
    end

    fpr_bank #(.NW(NW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .wdata(wdat), .words(words)
    );

    // Read assembly from post-write view (same-cycle forwarding)
    logic [127:0] r_next;
    always_comb begin
        r_next = '0;
        for (int i = 0; i < LANES; i++) begin
            int wi;
            wi = int'(r_base) + i;
            if (r_legal && (i < int'(r_n)) && (wi < NW))
                r_next[(int'(r_n) - 1 - i)*WORD_W +: WORD_W] = post[wi];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data    <= '0;
            rd_illegal <= 1'b0;
            wr_illegal <= 1'b0;
        end else begin
            if (rd_en)
                rd_data <= r_next;
            rd_illegal <= rd_en && !r_legal;
            wr_illegal <= wr_en && !w_legal;
        end
    end

    // R6/R7/R8: a rejected write leaves every word as it was
    a_r6_illegal_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |-> (words == $past(words)));

    // R8: a rejected read returns zero
    a_r8_illegal_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_illegal |-> (rd_data == '0));

    // R9: no read request, no change on the read bus
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> $stable(rd_data));

    // R10: same-cycle double write and read of one register forwards the data
    a_r10_forward_double: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && wr_en && rd_prec == 2'b01 && wr_prec == 2'b01 && rd_idx == wr_idx)
        |-> (rd_illegal || rd_data[63:0] == $past(wr_data[63:0])));
endmodule

// File: tb/tb_fp_alias_regfile.sv
module tb_fp_alias_regfile;
    localparam int NW = 64;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rd_en, wr_en;
    logic [1:0]   rd_prec, wr_prec;
    logic [5:0]   rd_idx, wr_idx;
    logic [127:0] wr_data, rd_data;
    logic         rd_illegal, wr_illegal;

    always #5 clk = ~clk;

    fp_alias_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .rd_en(rd_en), .rd_prec(rd_prec), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_illegal(rd_illegal),
        .wr_en(wr_en), .wr_prec(wr_prec), .wr_idx(wr_idx),
        .wr_data(wr_data), .wr_illegal(wr_illegal)
    );

    int tests = 0;
    int fails = 0;
    logic [31:0]  m [NW];
    logic [127:0] last_rd = '0;

    logic [127:0] qd  [$];
    bit           qri [$];
    bit           qwi [$];
    string        qt  [$];

    function automatic void decode(input logic [1:0] p, input logic [5:0] i,
                                   output bit ok, output int base, output int n);
        ok = 1'b0; base = 0; n = 0;
        case (p)
            2'b00: begin ok = (i < 32); base = int'(i); n = 1; end
            2'b01: begin ok = (i < 32); base = 2 * int'(i); n = 2; end
            2'b10: begin ok = (i < 32) && !i[0]; base = 2 * int'(i); n = 4; end
            default: ok = 1'b0;
        endcase
    endfunction

    task automatic check(input bit good, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        tests++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: update model, push expectation, drive ports at falling edge
    task automatic op(input bit re, input logic [1:0] rp, input logic [5:0] ri,
                      input bit we, input logic [1:0] wp, input logic [5:0] wi,
                      input logic [127:0] wd, input string tag);
        bit wok, rok;
        int wb, wn, rb, rn;
        logic [127:0] exp;
        @(negedge clk);
        decode(wp, wi, wok, wb, wn);
        if (we && wok)
            for (int k = 0; k < wn; k++) m[wb + k] = wd[(wn - 1 - k)*32 +: 32];
        decode(rp, ri, rok, rb, rn);
        if (re) begin
            exp = '0;
            if (rok)
                for (int k = 0; k < rn; k++) exp[(rn - 1 - k)*32 +: 32] = m[rb + k];
            last_rd = exp;
        end
        qd.push_back(last_rd);
        qri.push_back(re && !rok);
        qwi.push_back(we && !wok);
        qt.push_back(tag);
        rd_en = re; rd_prec = rp; rd_idx = ri;
        wr_en = we; wr_prec = wp; wr_idx = wi; wr_data = wd;
    endtask

    task automatic rd(input logic [1:0] p, input logic [5:0] i, input string tag);
        op(1'b1, p, i, 1'b0, 2'b00, 6'd0, '0, tag);
    endtask

    task automatic wr(input logic [1:0] p, input logic [5:0] i, input logic [127:0] d,
                      input string tag);
        op(1'b0, 2'b00, 6'd0, 1'b1, p, i, d, tag);
    endtask

    // Monitor: compare one item per cycle, 2 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (qd.size() > 0) begin
                logic [127:0] ed;
                bit eri, ewi;
                string t;
                ed = qd.pop_front(); eri = qri.pop_front();
                ewi = qwi.pop_front(); t = qt.pop_front();
                check(rd_data === ed, {t, " data"}, rd_data, ed);
                check(rd_illegal === eri, {t, " rd_illegal"}, 128'(rd_illegal), 128'(eri));
                check(wr_illegal === ewi, {t, " wr_illegal"}, 128'(wr_illegal), 128'(ewi));
            end
        end
    end

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < NW; k++) m[k] = '0;
        rst_n = 1'b0;
        rd_en = 0; rd_prec = 0; rd_idx = 0;
        wr_en = 0; wr_prec = 0; wr_idx = 0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(rd_data === '0, "R1 reset rd_data", rd_data, '0);
        check({rd_illegal, wr_illegal} === 2'b00, "R1 reset flags",
              128'({rd_illegal, wr_illegal}), '0);
        rd(2'b10, 6'd0,  "R1 quad 0 zero");
        rd(2'b10, 6'd30, "R1 quad 30 zero");

        wr(2'b00, 6'd0, 128'h0000_0000_0000_0000_0000_0000_AAAA_0001, "R2 wr s0");
        rd(2'b00, 6'd0, "R2 rd s0");
        rd(2'b01, 6'd0, "R2 s0 is upper of d0");
        wr(2'b00, 6'd1, 128'h1111_1111_2222_2222_3333_3333_BBBB_0002, "R2 wr s1");
        rd(2'b01, 6'd0, "R4 d0 = {s0,s1}");
        rd(2'b00, 6'd1, "R2 rd s1 upper zero");

        wr(2'b01, 6'd3, 128'h0_DDDD_0003_EEEE_0004, "R4 wr d3");
        wr(2'b00, 6'd6, 128'h0_CAFE_0006, "R3 wr s6");
        rd(2'b01, 6'd3, "R3 d3 lower kept");
        wr(2'b00, 6'd7, 128'h0_BEEF_0007, "R3 wr s7");
        rd(2'b01, 6'd3, "R3 d3 upper kept");

        wr(2'b10, 6'd4, 128'h4444_0001_4444_0002_4444_0003_4444_0004, "R5 wr q4");
        rd(2'b01, 6'd4, "R5 d4 upper of q4");
        rd(2'b01, 6'd5, "R5 d5 lower of q4");
        rd(2'b00, 6'd8, "R5 s8");
        rd(2'b00, 6'd11, "R5 s11");
        rd(2'b10, 6'd4, "R5 rd q4");

        wr(2'b10, 6'd5, {4{32'hDEAD_0BAD}}, "R6 wr odd quad");
        rd(2'b10, 6'd4, "R6 q4 unchanged");
        rd(2'b01, 6'd6, "R6 d6 unchanged");
        rd(2'b10, 6'd3, "R6 rd odd quad");

        wr(2'b01, 6'd20, 128'h0_E020_0001_E020_0002, "R7 wr d20");
        wr(2'b01, 6'd21, 128'h0_E021_0001_E021_0002, "R7 wr d21");
        rd(2'b10, 6'd20, "R7 rd q20");
        wr(2'b00, 6'd40, 128'h0_BAD0_0040, "R7 wr s40");
        rd(2'b01, 6'd20, "R7 d20 unchanged");
        rd(2'b00, 6'd33, "R7 rd s33");
        wr(2'b10, 6'd30, {4{32'h3030_3030}}, "R7 wr q30");
        rd(2'b01, 6'd31, "R7 rd d31");

        wr(2'b11, 6'd0, {4{32'hFFFF_FFFF}}, "R8 wr prec 3");
        rd(2'b01, 6'd0, "R8 d0 unchanged");
        rd(2'b11, 6'd2, "R8 rd prec 3");
        wr(2'b01, 6'd40, {4{32'h4040_4040}}, "R8 wr d40");
        rd(2'b10, 6'd32, "R8 rd q32");

        rd(2'b01, 6'd20, "R9 load");
        op(1'b0, 2'b01, 6'd0, 1'b0, 2'b00, 6'd0, '0, "R9 idle hold");
        op(1'b0, 2'b10, 6'd4, 1'b1, 2'b01, 6'd20, 128'h0_7777_0001_7777_0002, "R9 hold during write");

        op(1'b1, 2'b01, 6'd6, 1'b1, 2'b00, 6'd12, 128'h0_F0F0_0012, "R10 s12 into d6");
        op(1'b1, 2'b00, 6'd17, 1'b1, 2'b10, 6'd8,
           128'h8888_0001_8888_0002_8888_0003_8888_0004, "R10 q8 to s17");
        op(1'b1, 2'b01, 6'd9, 1'b1, 2'b01, 6'd9, 128'h0_9999_0001_9999_0002, "R10 d9 same");
        op(1'b1, 2'b10, 6'd0, 1'b1, 2'b01, 6'd1, 128'h0_1010_0001_1010_0002, "R10 d1 into q0");
        op(1'b1, 2'b01, 6'd9, 1'b1, 2'b10, 6'd9, {4{32'h5555_5555}}, "R10 illegal wr no fwd");

        op(1'b0, 2'b00, 6'd0, 1'b0, 2'b00, 6'd0, '0, "R9 final idle");
        @(negedge clk);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule